// File: doc/BRIEF.md
# Flash Erase Command Arbiter

This block sits between the byte-wide register write port of a microcontroller and the erase interface of a flash controller. Software arms an erase with a write to one of two arming registers. It then writes a trigger byte to a command register. The block checks the trigger byte against two exact codes and confirms that the matching arming write came first. If both hold, it raises one erase request with the target page number, or with the whole-array flag. The request stays up until the flash side returns a done strobe.

Each arming write is good for one erase only. A command that arrives without the arming it needs is discarded, and so is a command that arrives while an erase is already outstanding. A busy status bit shows that an erase is in flight, and a single-cycle completion pulse marks its end.

Top module: `flash_erase_arbiter`

## Requirements
- R1: After reset, `ers_req`, `busy`, `ers_cmpl`, `ers_mass` and `ers_page` are all 0, and no arming is held: a page trigger or a whole-array trigger written straight after reset starts nothing.
- R2: With `reg_sel` = 1 (page register), a write stores `reg_wdata[5:0]` as the page number and arms a page erase. A later write of 0x55 with `reg_sel` = 0 (command register) then raises `ers_req` = 1, `busy` = 1, `ers_mass` = 0 and `ers_page` = the stored page, on the clock edge that takes the command.
- R3: With `reg_sel` = 2 (enable register), a write with `reg_wdata[0]` = 1 arms a whole-array erase. A later command byte of 0xAA, taken while `dbg_en` = 1, raises `ers_req` = 1, `busy` = 1 and `ers_mass` = 1 on the edge that takes the command.
- R4: A command byte other than 0x55 or 0xAA starts nothing and leaves both armings intact.
- R5: A 0x55 command that is not preceded by a page-register write since the last page erase starts nothing.
- R6: A 0xAA command taken while the enable is clear, or while `dbg_en` = 0, starts nothing. A refusal caused by `dbg_en` = 0 leaves a set enable armed.
- R7: Each arming is used up by the erase it starts. A second trigger with no new arming write starts nothing.
- R8: `ers_req` and `busy` stay at 1 until `ers_done` is sampled high. On that edge both fall, and `ers_cmpl` is 1 for exactly the next cycle.
- R9: A command taken while `busy` = 1 is dropped and is not replayed after completion. Arming writes made while busy are kept for the next erase.
- R10: An enable-register write with `reg_wdata[0]` = 0 clears a pending whole-array arming.
- R11: While `ers_req` is 1, `ers_page` and `ers_mass` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_sel | input | 2 | Register select: 0 command, 1 page, 2 enable |
| reg_wdata | input | 8 | Write data byte |
| dbg_en | input | 1 | Debug port enabled; required for a whole-array erase |
| ers_done | input | 1 | Flash controller reports that the current erase has finished |
| ers_req | output | 1 | Erase request, held until done |
| ers_mass | output | 1 | 1 = whole-array erase, 0 = page erase |
| ers_page | output | 6 | Page number for a page erase |
| busy | output | 1 | Erase outstanding |
| ers_cmpl | output | 1 | One-cycle pulse after an erase completes |

## Verification
Every output is registered, so a command write, accepted or refused, shows its effect one edge after the cycle it is presented. A done strobe clears the request and busy at the edge that samples it, and the completion pulse is high for that one following cycle only. The bench drives each write on a falling edge, lets one rising edge take it, and reads the outputs at the next falling edge. It then reads once more to confirm that the pulse has dropped and that a dropped command has not come back. Refused commands are checked at the ports: the request must stay low, and a valid trigger that follows must still fire on the arming that was left in place.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_PAGE = 2'd1;
  localparam logic [1:0] SEL_MEN  = 2'd2;
  localparam logic [7:0] CODE_PAGE = 8'h55;
  localparam logic [7:0] CODE_MASS = 8'hAA;
endpackage

// File: rtl/flash_erase_arm.sv
// Holds the page number and the two one-shot arming flags.
module flash_erase_arm #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_page,
  input  logic              wr_men,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic              men_wdata,
  input  logic              use_page,
  input  logic              use_mass,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_armed,
  output logic              men_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q     <= '0;
      page_armed <= 1'b0;
      men_q      <= 1'b0;
    end else begin
      if (wr_page) begin
        page_q     <= page_wdata;
        page_armed <= 1'b1;
      end else if (use_page) begin
        page_armed <= 1'b0;
      end
      if (wr_men) begin
        men_q <= men_wdata;
      end else if (use_mass) begin
        men_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_erase_decode.sv
// Matches trigger codes against arming state; combinational.
module flash_erase_decode #(
  parameter int DATA_W = 8
) (
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              page_armed,
  input  logic              men_q,
  input  logic              dbg_en,
  input  logic              idle,
  output logic              go_page,
  output logic              go_mass
);
  import flash_erase_pkg::*;
  logic take;
  always_comb begin
    take    = cmd_wr && idle;
    go_page = take && (wdata == DATA_W'(CODE_PAGE)) && page_armed;
    go_mass = take && (wdata == DATA_W'(CODE_MASS)) && men_q && dbg_en;
  end
endmodule

// File: rtl/flash_erase_seq.sv
// Launches and holds the erase request until the flash side is done.
module flash_erase_seq #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_page,
  input  logic              go_mass,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              done,
  output logic              req,
  output logic              mass,
  output logic [PAGE_W-1:0] page,
  output logic              busy,
  output logic              cmpl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      mass <= 1'b0;
      page <= '0;
      busy <= 1'b0;
      cmpl <= 1'b0;
    end else begin
      cmpl <= 1'b0;
      if (busy) begin
        if (done) begin
          req  <= 1'b0;
          busy <= 1'b0;
          cmpl <= 1'b1;
        end
      end else if (go_page || go_mass) begin
        req  <= 1'b1;
        busy <= 1'b1;
        mass <= go_mass;
        page <= go_mass ? '0 : page_in;
      end
    end
  end
endmodule

// File: rtl/flash_erase_arbiter.sv
module flash_erase_arbiter #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              dbg_en,
  input  logic              ers_done,
  output logic              ers_req,
  output logic              ers_mass,
  output logic [PAGE_W-1:0] ers_page,
  output logic              busy,
  output logic              ers_cmpl
);
  import flash_erase_pkg::*;

  logic              wr_cmd, wr_page, wr_men;
  logic [PAGE_W-1:0] page_q;
  logic              page_armed, men_q;
  logic              go_page, go_mass;

  assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD);
  assign wr_page = reg_wr && (reg_sel == SEL_PAGE);
  assign wr_men  = reg_wr && (reg_sel == SEL_MEN);

  flash_erase_arm #(.PAGE_W(PAGE_W)) u_arm (
    .clk(clk), .rst(rst), .wr_page(wr_page), .wr_men(wr_men),
    .page_wdata(reg_wdata[PAGE_W-1:0]), .men_wdata(reg_wdata[0]),
    .use_page(go_page), .use_mass(go_mass),
    .page_q(page_q), .page_armed(page_armed), .men_q(men_q)
  );

  flash_erase_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_wr(wr_cmd), .wdata(reg_wdata), .page_armed(page_armed),
    .men_q(men_q), .dbg_en(dbg_en), .idle(!busy),
    .go_page(go_page), .go_mass(go_mass)
  );

  flash_erase_seq #(.PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst(rst), .go_page(go_page), .go_mass(go_mass),
    .page_in(page_q), .done(ers_done), .req(ers_req), .mass(ers_mass),
    .page(ers_page), .busy(busy), .cmpl(ers_cmpl)
  );
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dbg_en,
  input logic              ers_done,
  input logic              ers_req,
  input logic              ers_mass,
  input logic [PAGE_W-1:0] ers_page,
  input logic              busy,
  input logic              ers_cmpl
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !ers_req && !busy && !ers_cmpl);
  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    ers_req && !ers_done |=> ers_req);
  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ers_req && ers_done |=> !ers_req && !busy && ers_cmpl);
  // R8
  cmpl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ers_cmpl |=> !ers_cmpl);
  // R8
  fall_cmpl_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ers_cmpl);
  // R11
  stable_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    ers_req && !ers_done |=> $stable(ers_page) && $stable(ers_mass));
  // R4
  code_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ers_req) |-> $past(reg_wr && reg_sel == 2'd0 &&
      (reg_wdata == DATA_W'(8'h55) || reg_wdata == DATA_W'(8'hAA))));
  // R3
  mass_dbg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ers_req) && ers_mass |-> $past(dbg_en));
endmodule

bind flash_erase_arbiter flash_erase_chk #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .dbg_en(dbg_en), .ers_done(ers_done), .ers_req(ers_req), .ers_mass(ers_mass),
  .ers_page(ers_page), .busy(busy), .ers_cmpl(ers_cmpl)
);

// File: tb/sim_flash_erase_arbiter.sv
module sim_flash_erase_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_CMD = 2'd0, S_PAGE = 2'd1, S_MEN = 2'd2;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, dbg_en = 1'b1, ers_done = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic ers_req, ers_mass, busy, ers_cmpl;
  logic [5:0] ers_page;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_arbiter u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dbg_en(dbg_en), .ers_done(ers_done), .ers_req(ers_req), .ers_mass(ers_mass),
    .ers_page(ers_page), .busy(busy), .ers_cmpl(ers_cmpl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, taken at the rising edge, return at the next falling edge
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_erase(input string tag);
    ers_done = 1'b1;
    @(negedge clk);
    ers_done = 1'b0;
    chk({tag, " req cleared"}, ers_req, 0);
    chk({tag, " busy cleared"}, busy, 0);
    chk({tag, " cmpl pulse"}, ers_cmpl, 1);
    @(negedge clk);
    chk({tag, " cmpl one cycle"}, ers_cmpl, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", ers_req, 0);
    chk("R1 busy", busy, 0);
    chk("R1 cmpl", ers_cmpl, 0);
    chk("R1 mass", ers_mass, 0);
    chk("R1 page", ers_page, 0);
    wr(S_CMD, 8'h55);
    chk("R1 R5 page trigger unarmed", ers_req, 0);
    wr(S_CMD, 8'hAA);
    chk("R1 mass trigger unarmed", ers_req, 0);

    // R2 sweep every page; upper data bits set to show they are ignored
    for (int p = 0; p < 64; p++) begin
      wr(S_PAGE, 8'(p) | 8'hC0);
      wr(S_CMD, 8'h55);
      chk("R2 req", ers_req, 1);
      chk("R2 busy", busy, 1);
      chk("R2 mass", ers_mass, 0);
      chk("R2 page", ers_page, p);
      repeat (2) @(negedge clk);
      chk("R8 held", ers_req, 1);
      chk("R11 page stable", ers_page, p);
      finish_erase("R8");
      wr(S_CMD, 8'h55);
      chk("R7 page arming used", ers_req, 0);
    end

    // R3 whole-array erase, then R7 consumption
    wr(S_MEN, 8'h01);
    wr(S_CMD, 8'hAA);
    chk("R3 req", ers_req, 1);
    chk("R3 mass", ers_mass, 1);
    chk("R3 busy", busy, 1);
    finish_erase("R8 mass");
    wr(S_CMD, 8'hAA);
    chk("R7 enable used", ers_req, 0);

    // R6 debug port gate keeps the arming
    wr(S_MEN, 8'h01);
    dbg_en = 1'b0;
    wr(S_CMD, 8'hAA);
    chk("R6 dbg off", ers_req, 0);
    dbg_en = 1'b1;
    wr(S_CMD, 8'hAA);
    chk("R6 arming kept", ers_req, 1);
    chk("R6 mass", ers_mass, 1);
    finish_erase("R8");

    // R10 clearing the enable; only bit 0 counts
    wr(S_MEN, 8'h01);
    wr(S_MEN, 8'h00);
    wr(S_CMD, 8'hAA);
    chk("R10 cleared", ers_req, 0);
    wr(S_MEN, 8'hFE);
    wr(S_CMD, 8'hAA);
    chk("R10 bit0 only", ers_req, 0);

    // R4 every other code has no effect
    wr(S_PAGE, 8'd5);
    wr(S_MEN, 8'h01);
    for (int v = 0; v < 256; v++) begin
      if (v != 8'h55 && v != 8'hAA) begin
        wr(S_CMD, 8'(v));
        chk("R4 no effect", ers_req, 0);
      end
    end
    wr(S_CMD, 8'h55);
    chk("R4 page arming kept", ers_req, 1);
    chk("R4 page", ers_page, 5);
    finish_erase("R8");
    wr(S_CMD, 8'hAA);
    chk("R4 enable kept", ers_mass, 1);
    chk("R4 mass req", ers_req, 1);
    finish_erase("R8");

    // R9 commands while busy are dropped; arming while busy kept
    wr(S_PAGE, 8'd9);
    wr(S_CMD, 8'h55);
    chk("R9 start", ers_req, 1);
    wr(S_PAGE, 8'd12);
    wr(S_MEN, 8'h01);
    wr(S_CMD, 8'hAA);
    chk("R9 no switch mass", ers_mass, 0);
    chk("R11 page during busy", ers_page, 9);
    wr(S_CMD, 8'h55);
    chk("R9 page still", ers_page, 9);
    finish_erase("R9");
    chk("R9 not replayed", ers_req, 0);
    wr(S_CMD, 8'h55);
    chk("R9 new page arming", ers_page, 12);
    chk("R9 new req", ers_req, 1);
    finish_erase("R9");
    wr(S_CMD, 8'hAA);
    chk("R9 enable kept", ers_mass, 1);
    finish_erase("R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule